// File: doc/BRIEF.md
# Indirect-Indexed Codec Register File

This block is the control-register front end of an audio codec. A host reaches it through a small word-addressed bus. The window holds sixteen 32-bit word registers. One word register acts as a pointer. Its low five bits choose one of thirty-two 8-bit indirect registers. A second word register is the data port for the indirect register that the pointer selects. Reads are combinational and return data in the same cycle as the address. Writes take effect on the rising clock edge while the write strobe is high.

Several registers follow fixed access rules:
- One indirect entry is write-only and always reads back as zero.
- Two indirect entries are read-only and ignore writes.
- One indirect entry keeps a fixed set of version bits and takes only one host-controlled bit.
- One word register is read-only.
- One word register is a control register whose low bit starts a software reset of the whole file. That register still keeps the value that was written to it.

The interrupt output is never asserted.

Top module: `codec_regfile`

## Requirements
- R1: A write to any word address other than 1, 2 and 4 stores the full 32-bit data. A read of that word address returns the stored value in the same cycle. Word 0 reads back all 32 bits that were written to it.
- R2: The indirect pointer is bits [4:0] of word 0. Upper bits of word 0 are ignored for selection. A write to word address 1 stores bits [7:0] of the data into the selected indirect register. A read of word address 1 returns that byte, zero-extended to 32 bits.
- R3: A read through word address 1 while the pointer is 3 always returns 0, including after a nonzero write to that index.
- R4: Writes through word address 1 while the pointer is 11 or 25 leave those registers unchanged.
- R5: A write through word address 1 while the pointer is 12 stores (data & 0x40) | 0x8A.
- R6: After a synchronous reset (rst high at a clock edge), every word register and every indirect register reads 0, except indirect 12, which reads 0x8A, and indirect 25, which reads 0xA0.
- R7: Writes to word address 2 are ignored, and word address 2 reads 0.
- R8: A write to word address 4 with data bit 0 set applies the reset values of R6 to every register in the same edge. Word 4 then holds data & 0x7F.
- R9: A write to word address 4 with data bit 0 clear stores data & 0x7F in word 4 and leaves every other register unchanged.
- R10: The interrupt output irq is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_waddr | input | 4 | Word address inside the 16-word window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_waddr |
| irq | output | 1 | Interrupt request, held low |

## Verification
The embedded properties assume that rst is held high through the first clock edge, so that every register has a defined value before any check applies. They also assume that bus_wr and bus_waddr are stable around each rising edge. The bench meets both assumptions: it asserts rst from time zero, and it changes every bus input only on the falling edge. The bench samples the combinational read data one time step after it sets the address. Every write strobe lasts exactly one cycle, so no write is applied twice.

// File: rtl/codec_rf_pkg.sv
package codec_rf_pkg;
  // Window geometry
  localparam int WORD_W   = 32;
  localparam int N_WORDS  = 16;
  localparam int WADDR_W  = $clog2(N_WORDS);
  localparam int IND_W    = 8;
  localparam int N_IND    = 32;
  localparam int IIDX_W   = $clog2(N_IND);

  // Word register roles
  localparam int WR_POINTER = 0;
  localparam int WR_PORT    = 1;
  localparam int WR_LOCKED  = 2;
  localparam int WR_CTRL    = 4;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0000_007F;

  // Indirect register roles
  localparam int IR_HIDDEN   = 3;
  localparam int IR_FIXED_A  = 11;
  localparam int IR_MIXED    = 12;
  localparam int IR_FIXED_B  = 25;
  localparam logic [IND_W-1:0] MIXED_CONST = 8'h8A;
  localparam logic [IND_W-1:0] MIXED_OPEN  = 8'h40;
  localparam logic [IND_W-1:0] FIXED_B_VAL = 8'hA0;

  function automatic logic [IND_W-1:0] ind_init(input int idx);
    if (idx == IR_MIXED)        return MIXED_CONST;
    else if (idx == IR_FIXED_B) return FIXED_B_VAL;
    else                        return '0;
  endfunction
endpackage

// File: rtl/codec_rf_words.sv
module codec_rf_words
  import codec_rf_pkg::*;
#(
  parameter int NW = N_WORDS,
  parameter int DW = WORD_W,
  parameter int AW = $clog2(NW),
  parameter int PW = IIDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_rst,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [PW-1:0] pointer
);
  logic [DW-1:0] words [NW];

  // One register slot per word; the role of the slot picks its write rule
  for (genvar i = 0; i < NW; i++) begin : g_word
    if (i == WR_PORT || i == WR_LOCKED) begin : g_fixed
      always_ff @(posedge clk) begin
        words[i] <= '0;
      end
    end else if (i == WR_CTRL) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)                                   words[i] <= '0;
        else if (wr_en && waddr == AW'(i))         words[i] <= wdata & DW'(CTRL_KEEP);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)                                   words[i] <= '0;
        else if (wr_en && waddr == AW'(i))         words[i] <= wdata;
        else if (soft_rst)                         words[i] <= '0;
      end
    end
  end

  assign rdata   = words[waddr];
  assign pointer = words[WR_POINTER][PW-1:0];

  // R7: the locked word never carries data
  p_locked_zero_r7: assert property (@(posedge clk) disable iff (rst)
    words[WR_LOCKED] == '0);
  // R8/R9: the control word never holds bits above the kept mask
  p_ctrl_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (words[WR_CTRL] & ~DW'(CTRL_KEEP)) == '0);
endmodule

// File: rtl/codec_rf_indirect.sv
module codec_rf_indirect
  import codec_rf_pkg::*;
#(
  parameter int NI = N_IND,
  parameter int DW = IND_W,
  parameter int IW = $clog2(NI)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NI];

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NI; i++) mem[i] <= DW'(ind_init(i));
    end else if (wr_en) begin
      if (idx == IW'(IR_FIXED_A) || idx == IW'(IR_FIXED_B)) begin
        mem[idx] <= mem[idx];
      end else if (idx == IW'(IR_MIXED)) begin
        mem[idx] <= (wdata & DW'(MIXED_OPEN)) | DW'(MIXED_CONST);
      end else begin
        mem[idx] <= wdata;
      end
    end
  end

  assign rdata = (idx == IW'(IR_HIDDEN)) ? '0 : mem[idx];

  // R4: read-only entries survive a write aimed at them
  p_fixed_a_hold_r4: assert property (@(posedge clk) disable iff (clr)
    (wr_en && idx == IW'(IR_FIXED_A)) |=> mem[IR_FIXED_A] == $past(mem[IR_FIXED_A]));
  // R4 and R6: entry 25 keeps its identity value at all times
  p_fixed_b_value_r4: assert property (@(posedge clk) disable iff (rst)
    mem[IR_FIXED_B] == DW'(FIXED_B_VAL));
  // R5: the mixed entry always keeps its constant bits
  p_mixed_const_r5: assert property (@(posedge clk) disable iff (rst)
    (mem[IR_MIXED] & DW'(MIXED_CONST)) == DW'(MIXED_CONST));
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_rf_pkg::*;
#(
  parameter int NW = N_WORDS,
  parameter int DW = WORD_W,
  parameter int NI = N_IND,
  parameter int IDW = IND_W,
  localparam int AW = $clog2(NW),
  localparam int IW = $clog2(NI)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_waddr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic          at_port;
  logic          soft_rst;
  logic [IW-1:0] pointer;
  logic [DW-1:0] word_rdata;
  logic [IDW-1:0] ind_rdata;

  assign at_port  = (bus_waddr == AW'(WR_PORT));
  assign soft_rst = bus_wr && (bus_waddr == AW'(WR_CTRL)) && bus_wdata[0];

  codec_rf_words #(.NW(NW), .DW(DW), .AW(AW), .PW(IW)) u_words (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .wr_en    (bus_wr && !at_port),
    .waddr    (bus_waddr),
    .wdata    (bus_wdata),
    .rdata    (word_rdata),
    .pointer  (pointer)
  );

  codec_rf_indirect #(.NI(NI), .DW(IDW), .IW(IW)) u_ind (
    .clk   (clk),
    .rst   (rst),
    .clr   (rst || soft_rst),
    .wr_en (bus_wr && at_port),
    .idx   (pointer),
    .wdata (bus_wdata[IDW-1:0]),
    .rdata (ind_rdata)
  );

  assign bus_rdata = at_port ? DW'(ind_rdata) : word_rdata;
  assign irq       = 1'b0;

  // R8: a software reset leaves the pointer at index 0 one edge later
  p_soft_reset_ptr_r8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> pointer == '0);
  // R2: a write to the port does not move the pointer
  p_port_keeps_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && at_port) |=> pointer == $past(pointer));
endmodule

// File: tb/codec_regfile_test.sv
module codec_regfile_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  codec_regfile uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // Vector: {write, word address, data, expected read, requirement number}
  localparam int NV = 34;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 4'd0,  32'h0,        32'h0,        8'd6},  // R6 pointer clear
    {1'b0, 4'd1,  32'h0,        32'h0,        8'd6},  // R6 entry 0 clear
    {1'b1, 4'd0,  32'd12,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h8A,       8'd6},  // R6 entry 12
    {1'b1, 4'd0,  32'd25,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'hA0,       8'd6},  // R6 entry 25
    {1'b1, 4'd1,  32'hFF,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'hA0,       8'd4},  // R4 entry 25 locked
    {1'b1, 4'd0,  32'd11,       32'h0,        8'd0},
    {1'b1, 4'd1,  32'h55,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h0,        8'd4},  // R4 entry 11 locked
    {1'b1, 4'd0,  32'd12,       32'h0,        8'd0},
    {1'b1, 4'd1,  32'hFF,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'hCA,       8'd5},  // R5 open bit set
    {1'b1, 4'd1,  32'h0,        32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h8A,       8'd5},  // R5 open bit clear
    {1'b1, 4'd0,  32'd3,        32'h0,        8'd0},
    {1'b1, 4'd1,  32'h77,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h0,        8'd3},  // R3 hidden entry
    {1'b1, 4'd0,  32'h25,       32'h0,        8'd0},
    {1'b1, 4'd1,  32'h12345678, 32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h78,       8'd2},  // R2 byte store
    {1'b0, 4'd0,  32'h0,        32'h25,       8'd1},  // R1 pointer word
    {1'b1, 4'd3,  32'hDEADBEEF, 32'h0,        8'd0},
    {1'b0, 4'd3,  32'h0,        32'hDEADBEEF, 8'd1},  // R1 plain word
    {1'b1, 4'd15, 32'hA5A55A5A, 32'h0,        8'd0},
    {1'b0, 4'd15, 32'h0,        32'hA5A55A5A, 8'd1},  // R1 last word
    {1'b1, 4'd2,  32'hFFFFFFFF, 32'h0,        8'd0},
    {1'b0, 4'd2,  32'h0,        32'h0,        8'd7},  // R7 locked word
    {1'b1, 4'd4,  32'hFFFFFFFE, 32'h0,        8'd0},
    {1'b0, 4'd4,  32'h0,        32'h7E,       8'd9},  // R9 mask
    {1'b0, 4'd3,  32'h0,        32'hDEADBEEF, 8'd9},  // R9 no reset
    {1'b1, 4'd0,  32'h45,       32'h0,        8'd0},
    {1'b0, 4'd1,  32'h0,        32'h78,       8'd2}   // R2 upper pointer bits ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_waddr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 irq after reset", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) begin
        bus_write(VEC[i][75:72], VEC[i][71:40]);
      end else begin
        bus_read(VEC[i][75:72], r);
        check($sformatf("R%0d vector %0d", VEC[i][7:0], i), r, VEC[i][39:8]);
      end
    end
    check("R10 irq after traffic", {31'b0, irq}, 32'h0);

    // R8: software reset through the control word
    bus_write(4'd4, 32'hFFFFFF81);
    bus_read(4'd4, r);  check("R8 control keeps masked value", r, 32'h1);
    bus_read(4'd0, r);  check("R8 pointer cleared", r, 32'h0);
    bus_read(4'd3, r);  check("R8 word 3 cleared", r, 32'h0);
    bus_read(4'd15, r); check("R8 word 15 cleared", r, 32'h0);
    bus_read(4'd1, r);  check("R8 entry 0 cleared", r, 32'h0);
    bus_write(4'd0, 32'd5);
    bus_read(4'd1, r);  check("R8 entry 5 cleared", r, 32'h0);
    bus_write(4'd0, 32'd12);
    bus_read(4'd1, r);  check("R8 entry 12 restored", r, 32'h8A);
    bus_write(4'd0, 32'd25);
    bus_read(4'd1, r);  check("R8 entry 25 restored", r, 32'hA0);

    // R6: hardware reset after fresh traffic
    bus_write(4'd0, 32'd7);
    bus_write(4'd1, 32'h99);
    bus_read(4'd1, r);  check("R2 entry 7 stored", r, 32'h99);
    bus_write(4'd6, 32'h0BADF00D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(4'd4, r);  check("R6 control cleared", r, 32'h0);
    bus_read(4'd6, r);  check("R6 word 6 cleared", r, 32'h0);
    bus_read(4'd0, r);  check("R6 pointer cleared", r, 32'h0);
    bus_write(4'd0, 32'd7);
    bus_read(4'd1, r);  check("R6 entry 7 cleared", r, 32'h0);
    bus_write(4'd0, 32'd12);
    bus_read(4'd1, r);  check("R6 entry 12 after reset", r, 32'h8A);
    check("R10 irq at end", {31'b0, irq}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule